// File: doc/BRIEF.md
# External Reset Pulse Generator

This block produces the external reset pulse that a watchdog expiry requests. A single-cycle trigger starts a pulse whose length is counted in ticks of a 1 MHz enable, so the length is given in microseconds. Software sets the length, the active level of the pin and the pin's drive style through one 32-bit configuration register. The pin is presented as a data value plus an output enable, so an open-drain pin can be modelled by releasing the enable.

The length field can be rewritten on any write. The active level and the drive style are guarded: each changes only when its own key byte sits in the top byte of the written word. A write carrying any other top byte changes the length and leaves the pin mode alone.

The control path is a two-state machine. ST_IDLE leaves to ST_ACTIVE on the START transition, which is a trigger pulse. ST_ACTIVE stays in place on the COUNT transition, a tick with count left. It returns to ST_IDLE on the EXPIRE transition, a tick with the count at zero. Any cycle with no tick holds the current state.

Top module: `extrst_pulse_gen`

## Requirements
- R1: After reset the register reads 0x0000_00FF: length field 0xFF, active-low, open-drain. The pin is released (pin_oe = 0), and a trigger at that point gives a pulse of 256 ticks.
- R2: Every write loads bits 19:0 of the data into the length field, whatever the top byte holds. The field reads back on bits 19:0.
- R3: A top byte of 0xA5 makes the pin active-high, and 0x5A makes it active-low. The current level reads back on bit 31 (1 = active high).
- R4: A top byte of 0xA8 selects push-pull drive, and 0x8A selects open-drain. The current drive style reads back on bit 30 (1 = push-pull).
- R5: Any top byte other than the four keys leaves bits 31 and 30 unchanged.
- R6: A trigger seen in idle asserts the pulse from the next cycle. With length field N, the pulse stays asserted for exactly N+1 tick cycles. It drops in the cycle after the last of those ticks.
- R7: A trigger that arrives while a pulse is active is ignored. The pulse still ends after N+1 ticks.
- R8: A write to the length field during a pulse leaves that pulse's length unchanged. Only pulses that start later use the new value.
- R9: In open-drain mode, pin_oe is 1 only while the pulse is asserted, and pin_out then carries the active level. Outside the pulse pin_oe is 0.
- R10: In push-pull mode, pin_oe is always 1. pin_out carries the active level during the pulse and the opposite level outside it.
- R11: Bits 29:20 of the read data always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 32 | Write data: key byte 31:24, length 19:0 |
| cfg_rdata | output | 32 | Read data: level 31, drive 30, length 19:0 |
| trig | input | 1 | Start request from the watchdog expiry |
| tick_1us | input | 1 | One-cycle enable at 1 MHz |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |

## Verification
A corrupted count register shows at the pins as a pulse that is one or more ticks too short or too long. This error appears at the pulse's trailing edge, which is within N+1 ticks of the trigger. A wrong mode bit shows at once: the register readback is wrong on the next cycle, and the pin_oe/pin_out pair is wrong in the very next idle or active cycle. A count that is reloaded by a late trigger or by a length write stretches the pulse. The bench measures every pulse in ticks against the length captured at its start, so this fault is caught on the pulse in which it happens.

// File: rtl/extrst_pkg.sv
`timescale 1ns/1ps
package extrst_pkg;
    localparam int REG_W   = 32;
    localparam int KEY_LSB = 24;
    localparam int POL_BIT = 31;
    localparam int DRV_BIT = 30;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PUSH = 8'hA8;
    localparam logic [7:0] KEY_DRV_OPEN = 8'h8A;

    typedef enum logic {
        ST_IDLE,
        ST_ACTIVE
    } pulse_state_e;

    typedef struct packed {
        logic active_high;
        logic push_pull;
    } pin_mode_t;
endpackage

// File: rtl/extrst_cfg_reg.sv
`timescale 1ns/1ps
module extrst_cfg_reg
    import extrst_pkg::*;
#(
    parameter int              DUR_W   = 20,
    parameter logic [DUR_W-1:0] DUR_RST = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [DUR_W-1:0]  dur_o,
    output pin_mode_t         mode_o,
    output logic [REG_W-1:0]  rdata_o
);
    localparam int GAP_W = KEY_LSB - DUR_W;

    logic [DUR_W-1:0] dur_q;
    pin_mode_t        mode_q;
    logic [7:0]       key;

    assign key = wdata[REG_W-1:KEY_LSB];

    logic unused_gap;
    assign unused_gap = ^wdata[KEY_LSB-1:DUR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dur_q  <= DUR_RST;
            mode_q <= '0;
        end else if (wr_en) begin
            dur_q <= wdata[DUR_W-1:0];
            case (key)
                KEY_POL_HIGH: mode_q.active_high <= 1'b1;
                KEY_POL_LOW:  mode_q.active_high <= 1'b0;
                KEY_DRV_PUSH: mode_q.push_pull   <= 1'b1;
                KEY_DRV_OPEN: mode_q.push_pull   <= 1'b0;
                default:      mode_q             <= mode_q;
            endcase
        end
    end

    always_comb begin
        rdata_o                 = '0;
        rdata_o[DUR_W-1:0]      = dur_q;
        rdata_o[POL_BIT]        = mode_q.active_high;
        rdata_o[DRV_BIT]        = mode_q.push_pull;
    end

    assign dur_o  = dur_q;
    assign mode_o = mode_q;

    if (GAP_W < 0) begin : g_bad_width
        initial $error("DUR_W must not exceed the key byte position");
    end
endmodule

// File: rtl/extrst_pulse_fsm.sv
`timescale 1ns/1ps
module extrst_pulse_fsm
    import extrst_pkg::*;
#(
    parameter int DUR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             tick,
    input  logic [DUR_W-1:0] dur,
    output logic             pulse_on,
    output logic [DUR_W-1:0] remain
);
    pulse_state_e     state_q, state_d;
    logic [DUR_W-1:0] remain_q, remain_d;

    // next-state and counter
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin                 // START
                    state_d  = ST_ACTIVE;
                    remain_d = dur;
                end
            end
            ST_ACTIVE: begin
                if (tick) begin
                    if (remain_q == '0) begin   // EXPIRE
                        state_d = ST_IDLE;
                    end else begin              // COUNT
                        remain_d = remain_q - 1'b1;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    // outputs
    always_comb begin
        pulse_on = (state_q == ST_ACTIVE);
        remain   = remain_q;
    end
endmodule

// File: rtl/extrst_pin_drv.sv
`timescale 1ns/1ps
module extrst_pin_drv
    import extrst_pkg::*;
(
    input  logic      pulse_on,
    input  pin_mode_t mode,
    output logic      pin_out,
    output logic      pin_oe
);
    always_comb begin
        pin_out = pulse_on ? mode.active_high : ~mode.active_high;
        pin_oe  = mode.push_pull | pulse_on;
    end
endmodule

// File: rtl/extrst_pulse_gen.sv
`timescale 1ns/1ps
module extrst_pulse_gen
    import extrst_pkg::*;
#(
    parameter int               DUR_W   = 20,
    parameter logic [DUR_W-1:0] DUR_RST = 'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        trig,
    input  logic        tick_1us,
    output logic        pin_out,
    output logic        pin_oe
);
    logic [DUR_W-1:0] dur;
    pin_mode_t        mode;
    logic             pulse_on;
    logic [DUR_W-1:0] remain;

    extrst_cfg_reg #(.DUR_W(DUR_W), .DUR_RST(DUR_RST)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wdata   (cfg_wdata),
        .dur_o   (dur),
        .mode_o  (mode),
        .rdata_o (cfg_rdata)
    );

    extrst_pulse_fsm #(.DUR_W(DUR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .tick     (tick_1us),
        .dur      (dur),
        .pulse_on (pulse_on),
        .remain   (remain)
    );

    extrst_pin_drv u_pin (
        .pulse_on (pulse_on),
        .mode     (mode),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );
endmodule

// File: rtl/extrst_checker.sv
`timescale 1ns/1ps
module extrst_checker #(
    parameter int DUR_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [31:0]      cfg_wdata,
    input logic [31:0]      cfg_rdata,
    input logic             trig,
    input logic             tick_1us,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             pulse_on,
    input logic [DUR_W-1:0] remain
);
    logic is_key;
    assign is_key = (cfg_wdata[31:24] == 8'hA5) || (cfg_wdata[31:24] == 8'h5A) ||
                    (cfg_wdata[31:24] == 8'hA8) || (cfg_wdata[31:24] == 8'h8A);

    AST_DUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rdata[DUR_W-1:0] == $past(cfg_wdata[DUR_W-1:0])); // R2
    AST_POL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wdata[31:24] == 8'hA5) |=> cfg_rdata[31]); // R3
    AST_DRV_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wdata[31:24] == 8'h8A) |=> !cfg_rdata[30]); // R4
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !is_key) |=> $stable(cfg_rdata[31:30])); // R5
    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_on && trig) |=> (pulse_on && remain == $past(cfg_rdata[DUR_W-1:0]))); // R6
    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_on && !tick_1us) |=> (pulse_on && $stable(remain))); // R7
    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_on && tick_1us && remain != '0) |=> (pulse_on && remain == $past(remain) - 1'b1)); // R8
    AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[30] && !pulse_on) |-> !pin_oe); // R9
    AST_PP_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[30] |-> (pin_oe && pin_out == (pulse_on ~^ cfg_rdata[31]))); // R10
    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rdata[29:20] == '0); // R11
endmodule

bind extrst_pulse_gen extrst_checker #(.DUR_W(DUR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .trig      (trig),
    .tick_1us  (tick_1us),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pulse_on  (pulse_on),
    .remain    (remain)
);

// File: tb/extrst_pulse_gen_tb.sv
`timescale 1ns/1ps
module extrst_pulse_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        trig = 1'b0;
    logic        tick_1us = 1'b0;
    logic        pin_out, pin_oe;

    int n_chk = 0;
    int n_fail = 0;

    logic        m_pol = 1'b0;
    logic        m_drv = 1'b0;
    logic [19:0] m_dur = 20'hFF;

    always #2.5 clk = ~clk;

    extrst_pulse_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .trig(trig), .tick_1us(tick_1us),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit seen_active();
        return pin_oe && (pin_out == m_pol);
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (d[31:24])
            8'hA5: m_pol = 1'b1;
            8'h5A: m_pol = 1'b0;
            8'hA8: m_drv = 1'b1;
            8'h8A: m_drv = 1'b0;
            default: ;
        endcase
        m_dur = d[19:0];
    endtask

    task automatic check_idle_pins(input string tag);
        if (m_drv) begin
            chk(pin_oe == 1'b1 && pin_out == ~m_pol, "R10", {tag, " push-pull idle"},
                {30'd0, pin_oe, pin_out}, {30'd0, 1'b1, ~m_pol});
        end else begin
            chk(pin_oe == 1'b0, "R9", {tag, " open-drain idle released"},
                {31'd0, pin_oe}, 32'd0);
        end
    endtask

    // Fires one pulse; counts ticks delivered while the pins show it asserted.
    task automatic fire(input int per, input int retrig_at, input int rewrite_at,
                        input logic [19:0] newdur, output int cnt);
        int c;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(seen_active(), "R6", "pulse asserted cycle after trigger",
            {30'd0, pin_oe, pin_out}, {30'd0, 1'b1, m_pol});
        if (m_drv) chk(pin_oe && pin_out == m_pol, "R10", "push-pull active level",
                       {30'd0, pin_oe, pin_out}, {30'd0, 1'b1, m_pol});
        else       chk(pin_oe && pin_out == m_pol, "R9", "open-drain driven in pulse",
                       {30'd0, pin_oe, pin_out}, {30'd0, 1'b1, m_pol});
        c = 0;
        cnt = 0;
        while (seen_active() && c < 5000) begin
            tick_1us = ((c % per) == 0);
            if (tick_1us) cnt++;
            trig = (c == retrig_at);
            if (c == rewrite_at) begin
                cfg_wr_en = 1'b1;
                cfg_wdata = {12'h000, newdur};
            end else begin
                cfg_wr_en = 1'b0;
            end
            @(negedge clk);
            c++;
        end
        tick_1us = 1'b0;
        trig = 1'b0;
        cfg_wr_en = 1'b0;
        if (rewrite_at >= 0) m_dur = newdur;
        check_idle_pins("after pulse");
    endtask

    task automatic set_mode(input logic pol, input logic drv);
        wr({(pol ? 8'hA5 : 8'h5A), 4'h0, m_dur});
        chk(cfg_rdata[31] == pol, "R3", "polarity key readback", {31'd0, cfg_rdata[31]}, {31'd0, pol});
        wr({(drv ? 8'hA8 : 8'h8A), 4'h0, m_dur});
        chk(cfg_rdata[30] == drv, "R4", "drive key readback", {31'd0, cfg_rdata[30]}, {31'd0, drv});
        chk(cfg_rdata[31] == pol, "R5", "drive key kept polarity", {31'd0, cfg_rdata[31]}, {31'd0, pol});
    endtask

    task automatic sweep_top_byte();
        for (int b = 0; b < 256; b++) begin
            logic [1:0]  prev;
            logic [19:0] d;
            if (b == 8'hA5 || b == 8'h5A || b == 8'hA8 || b == 8'h8A) continue;
            prev = cfg_rdata[31:30];
            d = 20'((b * 4099 + 7) & 20'hFFFFF);
            wr({b[7:0], 4'hF, d});
            chk(cfg_rdata[31:30] == prev, "R5", "non-key top byte kept mode",
                {30'd0, cfg_rdata[31:30]}, {30'd0, prev});
            chk(cfg_rdata[19:0] == d, "R2", "length loaded on non-key write",
                {12'd0, cfg_rdata[19:0]}, {12'd0, d});
            chk(cfg_rdata[29:20] == 10'd0, "R11", "gap bits read zero",
                {22'd0, cfg_rdata[29:20]}, 32'd0);
        end
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 32'h0000_00FF, "R1", "reset register value", cfg_rdata, 32'h0000_00FF);
        chk(pin_oe == 1'b0, "R1", "pin released after reset", {31'd0, pin_oe}, 32'd0);

        fire(1, -1, -1, 20'd0, cnt);
        chk(cnt == 256, "R1", "default pulse length in ticks", cnt, 256);

        sweep_top_byte();
        set_mode(1'b1, 1'b1);
        sweep_top_byte();

        // key written with a length: both take effect (R2, R3)
        wr({8'h5A, 4'h0, 20'h12345});
        chk(cfg_rdata == 32'h4001_2345, "R2", "key write also loads length",
            cfg_rdata, 32'h4001_2345);

        for (int m = 0; m < 4; m++) begin
            set_mode(m[0], m[1]);
            check_idle_pins("mode sweep");
            for (int n = 0; n < 8; n++) begin
                wr({8'h00, 4'h0, 20'(n)});
                fire(1 + (n % 3), -1, -1, 20'd0, cnt);
                chk(cnt == n + 1, "R6", "pulse length N+1 ticks", cnt, n + 1);
            end
        end

        // R7: retriggers during the pulse are ignored
        set_mode(1'b0, 1'b0);
        wr({8'h00, 4'h0, 20'd5});
        fire(2, 3, -1, 20'd0, cnt);
        chk(cnt == 6, "R7", "retrigger mid pulse ignored", cnt, 6);
        fire(1, 4, -1, 20'd0, cnt);
        chk(cnt == 6, "R7", "retrigger near end ignored", cnt, 6);

        // R8: length written during a pulse applies to the next one only
        set_mode(1'b1, 1'b1);
        wr({8'h00, 4'h0, 20'd4});
        fire(2, -1, 1, 20'd9, cnt);
        chk(cnt == 5, "R8", "current pulse keeps captured length", cnt, 5);
        chk(cfg_rdata[19:0] == 20'd9, "R8", "new length visible", {12'd0, cfg_rdata[19:0]}, 32'd9);
        fire(1, -1, -1, 20'd0, cnt);
        chk(cnt == 10, "R8", "next pulse uses new length", cnt, 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #750000;
        n_fail++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule